// File: doc/BRIEF.md
# Three-Pole Three-Zero Digital Compensator

This block turns a signed error sample into a PWM duty command. Each time a trigger arrives from the error converter, it takes one small signed error value and runs it through two IIR sections in series. The first is second order and the second is first order, which gives three poles and three zeros in total. The result is limited to a programmable window and presented as a 16-bit unsigned fraction of the switching period, where 0 means 0.0 and 65535 means just under 1.0. A one-cycle valid strobe marks each new value so a PWM engine can load it directly.

Several sets of filter coefficients are stored at once. A bank-select input picks the set used for each sample, so control can change loop tuning while the converter runs. Arithmetic is done on a single shared multiplier, stepped through eight products by a small sequencer. The delay line keeps the limited output value, which stops the first-order section from winding up while the output is pinned at a limit. A synchronous clear input empties the delay line.

Top module: `comp3_core`

## Requirements
- R1: During and after reset, `duty` is 0 and `duty_vld` is 0 until the first result.
- R2: Coefficients are signed Q2.14 and are indexed by tap: 0=b0, 1=b1, 2=b2, 3=a1, 4=a2, 5=c0, 6=c1, 7=d1. The first section computes y = b0·x + b1·x[n-1] + b2·x[n-2] + a1·y[n-1] + a2·y[n-2]. The second section computes u = c0·y + c1·y[n-1] + d1·u[n-1]. Each sum of products is shifted right by 14 with arithmetic rounding toward minus infinity.
- R3: The accumulation is 32-bit signed and saturates after every product instead of wrapping. The 14-bit-shifted result of each section saturates to 18-bit signed.
- R4: The output is u clamped to the window set by `duty_min` and `duty_max`, both unsigned. Values above `duty_max` give `duty_max`. Otherwise, values below `duty_min` give `duty_min`.
- R5: The stored u[n-1] is the clamped output, not the unclamped u.
- R6: `bank_sel` is sampled on the edge that accepts a trigger. Changing it while a computation runs has no effect on that result.
- R7: `duty_vld` is high for exactly one cycle, after the ninth rising edge following the edge that accepts a trigger. `duty` changes only in that cycle.
- R8: A trigger seen while a computation is in progress (within nine cycles of an accepted trigger) is ignored. The minimum trigger spacing is ten cycles.
- R9: `clr` zeroes all delay-line state and cancels any computation in progress without a strobe, leaving `duty` unchanged. A trigger in the same cycle as `clr` is dropped.
- R10: A coefficient write with `cw_en` high stores `cw_data` at bank `cw_bank`, tap `cw_tap`. Later samples that select that bank use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the filter delay line |
| trig | input | 1 | Sample strobe from the error converter |
| err_in | input | 6 | Signed error sample |
| bank_sel | input | 2 | Coefficient bank for the next sample |
| duty_min | input | 16 | Lower duty limit, unsigned fraction |
| duty_max | input | 16 | Upper duty limit, unsigned fraction |
| cw_en | input | 1 | Coefficient write enable |
| cw_bank | input | 2 | Coefficient write bank |
| cw_tap | input | 3 | Coefficient write tap index |
| cw_data | input | 16 | Coefficient value, signed Q2.14 |
| duty | output | 16 | Clamped duty command |
| duty_vld | output | 1 | One-cycle strobe marking a new duty value |

## Verification
The clear and the trigger can land on the same clock edge. The bench drives both in one cycle. It then confirms that no strobe appears for the whole window in which a result could have come out, and that `duty` keeps its earlier value. It also confirms that the next accepted sample matches a model whose delay line is all zeros. A clear that arrives in the middle of a running computation is judged the same way. A bank change in the middle of a computation is checked by comparing the result against the bank that was presented with the trigger.

// File: rtl/comp3_pkg.sv
package comp3_pkg;
  localparam int NTAP   = 8;
  localparam int TAP_B0 = 0;
  localparam int TAP_B1 = 1;
  localparam int TAP_B2 = 2;
  localparam int TAP_A1 = 3;
  localparam int TAP_A2 = 4;
  localparam int TAP_C0 = 5;
  localparam int TAP_C1 = 6;
  localparam int TAP_D1 = 7;
endpackage

// File: rtl/comp3_coef_ram.sv
module comp3_coef_ram #(
  parameter int CW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [CW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [CW-1:0] rdata
);
  logic signed [CW-1:0] mem [DEPTH];

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/comp3_sat_mac.sv
module comp3_sat_mac #(
  parameter int CW = 16,
  parameter int SW = 18,
  parameter int AW = 32
) (
  input  logic signed [CW-1:0] coef,
  input  logic signed [SW-1:0] opnd,
  input  logic signed [AW-1:0] acc_in,
  input  logic                 fresh,
  output logic signed [AW-1:0] acc_out
);
  localparam int PW   = CW + SW;
  localparam int SUMW = ((PW > AW) ? PW : AW) + 1;
  localparam logic signed [SUMW-1:0] HI = {{(SUMW-AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [SUMW-1:0] LO = {{(SUMW-AW+1){1'b1}}, {(AW-1){1'b0}}};

  logic signed [PW-1:0]   prod;
  logic signed [SUMW-1:0] base, pext, sum;

  always_comb begin
    prod = coef * opnd;
    pext = {{(SUMW-PW){prod[PW-1]}}, prod};
    base = fresh ? '0 : {{(SUMW-AW){acc_in[AW-1]}}, acc_in};
    sum  = base + pext;
    if (sum > HI)      acc_out = {1'b0, {(AW-1){1'b1}}};
    else if (sum < LO) acc_out = {1'b1, {(AW-1){1'b0}}};
    else               acc_out = sum[AW-1:0];
  end
endmodule

// File: rtl/comp3_clamp.sv
module comp3_clamp #(
  parameter int SW = 18,
  parameter int DW = 16
) (
  input  logic signed [SW-1:0] val,
  input  logic [DW-1:0]        lo,
  input  logic [DW-1:0]        hi,
  output logic [DW-1:0]        q
);
  logic signed [SW:0] v, l, h;

  always_comb begin
    v = {val[SW-1], val};
    l = {{(SW+1-DW){1'b0}}, lo};
    h = {{(SW+1-DW){1'b0}}, hi};
    if (v > h)      q = hi;   // upper limit checked first
    else if (v < l) q = lo;
    else            q = val[DW-1:0];
  end
endmodule

// File: rtl/comp3_core.sv
module comp3_core
  import comp3_pkg::*;
#(
  parameter int XW    = 6,
  parameter int CW    = 16,
  parameter int FRAC  = 14,
  parameter int SW    = 18,
  parameter int AW    = 32,
  parameter int DW    = 16,
  parameter int NBANK = 4,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int TW   = $clog2(NTAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 trig,
  input  logic signed [XW-1:0] err_in,
  input  logic [BW-1:0]        bank_sel,
  input  logic [DW-1:0]        duty_min,
  input  logic [DW-1:0]        duty_max,
  input  logic                 cw_en,
  input  logic [BW-1:0]        cw_bank,
  input  logic [TW-1:0]        cw_tap,
  input  logic signed [CW-1:0] cw_data,
  output logic [DW-1:0]        duty,
  output logic                 duty_vld
);
  localparam int STW   = $clog2(NTAP + 1);
  localparam int DEPTH = (1 << BW) * NTAP;
  localparam logic [STW-1:0] LAST = STW'(NTAP);
  localparam logic signed [AW-1:0] NMAX = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [AW-1:0] NMIN = {{(AW-SW+1){1'b1}}, {(SW-1){1'b0}}};

  function automatic logic signed [SW-1:0] narrow(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] s;
    s = a >>> FRAC;
    if (s > NMAX)      narrow = {1'b0, {(SW-1){1'b1}}};
    else if (s < NMIN) narrow = {1'b1, {(SW-1){1'b0}}};
    else               narrow = s[SW-1:0];
  endfunction

  logic                 busy;
  logic [STW-1:0]       step;
  logic [BW-1:0]        bank_l;
  logic signed [XW-1:0] x_cur, x1, x2;
  logic signed [SW-1:0] y1_1, y1_2, u_1;
  logic signed [AW-1:0] acc, mac_out;
  logic signed [SW-1:0] acc_n, opnd;
  logic signed [CW-1:0] coef_q;
  logic [DW-1:0]        clamp_q;
  logic                 start, fresh;
  logic [BW-1:0]        rd_bank;
  logic [TW-1:0]        rd_tap;

  assign start = trig && !busy && !clr;
  assign acc_n = narrow(acc);
  assign fresh = (step == STW'(TAP_B0)) || (step == STW'(TAP_C0));

  // coefficient for step k is fetched one cycle ahead
  always_comb begin
    if (busy) begin
      rd_bank = bank_l;
      rd_tap  = TW'(step + 1'b1);
    end else begin
      rd_bank = bank_sel;
      rd_tap  = TW'(TAP_B0);
    end
  end

  always_comb begin
    case (step)
      STW'(TAP_B0): opnd = {{(SW-XW){x_cur[XW-1]}}, x_cur};
      STW'(TAP_B1): opnd = {{(SW-XW){x1[XW-1]}}, x1};
      STW'(TAP_B2): opnd = {{(SW-XW){x2[XW-1]}}, x2};
      STW'(TAP_A1): opnd = y1_1;
      STW'(TAP_A2): opnd = y1_2;
      STW'(TAP_C0): opnd = acc_n;   // first-section output, just finished
      STW'(TAP_C1): opnd = y1_2;    // delay line already shifted
      STW'(TAP_D1): opnd = u_1;
      default:      opnd = '0;
    endcase
  end

  comp3_coef_ram #(.CW(CW), .DEPTH(DEPTH)) u_ram (
    .clk  (clk),
    .we   (cw_en),
    .waddr({cw_bank, cw_tap}),
    .wdata(cw_data),
    .raddr({rd_bank, rd_tap}),
    .rdata(coef_q)
  );

  comp3_sat_mac #(.CW(CW), .SW(SW), .AW(AW)) u_mac (
    .coef   (coef_q),
    .opnd   (opnd),
    .acc_in (acc),
    .fresh  (fresh),
    .acc_out(mac_out)
  );

  comp3_clamp #(.SW(SW), .DW(DW)) u_clamp (
    .val(acc_n),
    .lo (duty_min),
    .hi (duty_max),
    .q  (clamp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      step     <= '0;
      bank_l   <= '0;
      x_cur    <= '0;
      x1       <= '0;
      x2       <= '0;
      y1_1     <= '0;
      y1_2     <= '0;
      u_1      <= '0;
      acc      <= '0;
      duty     <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty_vld <= 1'b0;
      if (clr) begin
        busy <= 1'b0;
        step <= '0;
        x1   <= '0;
        x2   <= '0;
        y1_1 <= '0;
        y1_2 <= '0;
        u_1  <= '0;
      end else if (start) begin
        busy   <= 1'b1;
        step   <= '0;
        x_cur  <= err_in;
        bank_l <= bank_sel;
      end else if (busy) begin
        step <= step + 1'b1;
        if (step < LAST) acc <= mac_out;
        if (step == STW'(TAP_C0)) begin
          x2   <= x1;
          x1   <= x_cur;
          y1_2 <= y1_1;
          y1_1 <= acc_n;
        end
        if (step == LAST) begin
          duty     <= clamp_q;
          u_1      <= {{(SW-DW){1'b0}}, clamp_q};
          duty_vld <= 1'b1;
          busy     <= 1'b0;
        end
      end
    end
  end

  // R4: a result always lies inside a consistent window
  p_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    duty_vld && $past(duty_min <= duty_max) |->
      (duty >= $past(duty_min)) && (duty <= $past(duty_max)));

  // R7: strobe lasts one cycle
  p_vld_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    duty_vld |=> !duty_vld);

  // R7: output moves only together with its strobe
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty) |-> duty_vld);

  // R7: a strobe only ends a running computation
  p_vld_src_r7: assert property (@(posedge clk) disable iff (rst)
    duty_vld |-> $past(busy));

  // R6, R8: the latched bank cannot move inside a computation
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(bank_l));

  // R9: clear empties the delay line and stops the sequencer
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !busy && !duty_vld && x1 == '0 && x2 == '0 &&
            y1_1 == '0 && y1_2 == '0 && u_1 == '0);
endmodule

// File: tb/tb_comp3_core.sv
module tb_comp3_core;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clr = 1'b0;
  logic              trig = 1'b0;
  logic signed [5:0] err_in = '0;
  logic [1:0]        bank_sel = '0;
  logic [15:0]       duty_min = '0;
  logic [15:0]       duty_max = 16'hFFFF;
  logic              cw_en = 1'b0;
  logic [1:0]        cw_bank = '0;
  logic [2:0]        cw_tap = '0;
  logic signed [15:0] cw_data = '0;
  logic [15:0]       duty;
  logic              duty_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int     cf [4][8];
  longint mx1, mx2, my1, my2, mu1;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp3_core dut (
    .clk(clk), .rst(rst), .clr(clr), .trig(trig), .err_in(err_in),
    .bank_sel(bank_sel), .duty_min(duty_min), .duty_max(duty_max),
    .cw_en(cw_en), .cw_bank(cw_bank), .cw_tap(cw_tap), .cw_data(cw_data),
    .duty(duty), .duty_vld(duty_vld)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input int w);
    longint lim;
    lim = longint'(1) <<< (w - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic model_zero();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; mu1 = 0;
  endtask

  // arithmetic model of R2..R5
  task automatic model_step(input int x, input int b, output longint res);
    longint acc, y, u;
    acc = sat(longint'(cf[b][0]) * x, 32);
    acc = sat(acc + longint'(cf[b][1]) * mx1, 32);
    acc = sat(acc + longint'(cf[b][2]) * mx2, 32);
    acc = sat(acc + longint'(cf[b][3]) * my1, 32);
    acc = sat(acc + longint'(cf[b][4]) * my2, 32);
    y   = sat(acc >>> 14, 18);
    acc = sat(longint'(cf[b][5]) * y, 32);
    acc = sat(acc + longint'(cf[b][6]) * my1, 32);
    acc = sat(acc + longint'(cf[b][7]) * mu1, 32);
    u   = sat(acc >>> 14, 18);
    if (u > longint'(duty_max))      res = duty_max;
    else if (u < longint'(duty_min)) res = duty_min;
    else                             res = u;
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y; mu1 = res;
  endtask

  task automatic wr_coef(input int b, input int t, input int v);
    @(negedge clk);
    cw_en = 1'b1; cw_bank = 2'(b); cw_tap = 3'(t); cw_data = 16'(v);
    cf[b][t] = v;
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic load_bank(input int b, input int c0, input int c1, input int c2, input int c3,
                           input int c4, input int c5, input int c6, input int c7);
    wr_coef(b, 0, c0); wr_coef(b, 1, c1); wr_coef(b, 2, c2); wr_coef(b, 3, c3);
    wr_coef(b, 4, c4); wr_coef(b, 5, c5); wr_coef(b, 6, c6); wr_coef(b, 7, c7);
  endtask

  // one trigger; optional bank change and extra trigger inside the computation
  task automatic run_sample(input int x, input int b, input bit swap, input bit extra, input string req);
    longint expv;
    @(negedge clk);
    err_in = 6'(x); bank_sel = 2'(b); trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (swap && k == 2) bank_sel = 2'(b ^ 1);
      if (extra && k == 3) trig = 1'b1;
      if (extra && k == 4) trig = 1'b0;
    end
    chk(duty_vld == 1'b0, "R7", duty_vld, 0);
    @(negedge clk);
    model_step(x, b, expv);
    chk(duty_vld == 1'b1, "R7", duty_vld, 1);
    chk(longint'(duty) == expv, req, duty, expv);
  endtask

  task automatic watch_quiet(input int n, input longint hold, input string req);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (duty_vld) seen = 1;
    end
    chk(!seen, req, seen, 0);
    chk(longint'(duty) == hold, req, duty, hold);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint hold;
    model_zero();
    repeat (4) @(negedge clk);
    chk(duty == 16'd0, "R1", duty, 0);
    chk(duty_vld == 1'b0, "R1", duty_vld, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(duty == 16'd0 && duty_vld == 1'b0, "R1", duty, 0);

    load_bank(0, 6000, -2500, 900, 12000, -3000, 20000, -8000, 8000);
    load_bank(1, 16384, 16384, 0, 0, 0, 16384, 0, 0);
    load_bank(2, 16384, 0, 0, 0, 0, 16384, 0, 16384);
    load_bank(3, 32767, 0, 0, 32767, 0, 32767, 0, 0);

    // R2: full error sweep, both directions, general bank
    duty_min = 16'd0; duty_max = 16'hFFFF;
    for (int x = -32; x < 32; x++) run_sample(x, 0, 0, 0, "R2");
    for (int x = 31; x >= -32; x--) run_sample(x, 0, 0, 0, "R2");

    // R4: narrow window on a pass-through bank, clamps on both sides
    duty_min = 16'd20; duty_max = 16'd40;
    for (int x = -32; x < 32; x++) run_sample(x, 1, 0, 0, "R4");

    // R5: integrator pinned at the upper limit, then released
    duty_min = 16'd0; duty_max = 16'd300;
    for (int i = 0; i < 20; i++) run_sample(31, 2, 0, 0, "R5");
    for (int i = 0; i < 12; i++) run_sample(-32, 2, 0, 0, "R5");

    // R3: runaway gain drives both saturation stages
    duty_min = 16'd0; duty_max = 16'hFFFF;
    for (int i = 0; i < 24; i++) run_sample(31, 3, 0, 0, "R3");
    for (int i = 0; i < 24; i++) run_sample(-32, 3, 0, 0, "R3");

    // R6: bank input changed mid-computation
    for (int i = 0; i < 16; i++) run_sample(i - 8, i % 2, 1, 0, "R6");

    // R8: second trigger inside the busy window is ignored
    for (int i = 0; i < 4; i++) run_sample(5 * i - 9, 0, 0, 1, "R8");
    hold = duty;
    watch_quiet(12, hold, "R8");

    // R9: idle clear, then a sample from empty state
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_zero();
    run_sample(17, 0, 0, 0, "R9");

    // R9: clear and trigger in the same cycle
    hold = duty;
    @(negedge clk); clr = 1'b1; trig = 1'b1; err_in = 6'sd9; bank_sel = 2'd0;
    @(negedge clk); clr = 1'b0; trig = 1'b0;
    model_zero();
    watch_quiet(12, hold, "R9");
    run_sample(-11, 0, 0, 0, "R9");

    // R9: clear in the middle of a computation
    run_sample(13, 0, 0, 0, "R2");
    hold = duty;
    @(negedge clk); trig = 1'b1; err_in = 6'sd20;
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    model_zero();
    watch_quiet(12, hold, "R9");
    run_sample(7, 0, 0, 0, "R9");

    // R10: rewrite one coefficient and observe its effect
    duty_min = 16'd0; duty_max = 16'hFFFF;
    wr_coef(1, 5, 8192);
    for (int x = 0; x < 32; x += 4) run_sample(x, 1, 0, 0, "R10");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule